// File: doc/BRIEF.md
# I2C Slave Engine with General Call Recognition

This block is the target side of a two-wire serial bus. It oversamples the clock and data lines with the system clock and passes each through a synchronizer before looking for edges. It drives the data line only through an open-drain enable, so a high level on `sda_oe` pulls the line low. After a START it collects the first byte, which holds a 7-bit address and a direction bit. It answers when the address is its own programmed address, or when the address is the all-zero broadcast address in a write. It answers only while software holds the acknowledge-enable input high.

Once addressed, the engine either takes in data bytes and acknowledges each one, or sends bytes from its transmit register, most significant bit first. Every event loads a 3-bit status code and can set an interrupt flag that software clears. A START seen at any point returns the engine to the address phase. This lets a master that lost arbitration part way through a frame address the block again without a STOP in between.

Top module: `i2c_gc_slave`

## Requirements
- R1: START (SDA falling while SCL is high) releases SDA, clears the bit counter and enters the address phase from any state, including part way through a data byte, so a repeated START followed by a matching address is acknowledged.
- R2: An address byte whose upper 7 bits equal `own_addr` and whose bit 0 is 0 is acknowledged (SDA held low during the 9th SCL clock), and status becomes 1 (own address, write).
- R3: An own-address byte with bit 0 equal to 1 is acknowledged and status becomes 2 (own address, read).
- R4: The address byte 0x00 (general call, write) is acknowledged and status becomes 3; the byte 0x01 is not treated as a general call.
- R5: An address byte matching neither address gets no acknowledge, leaves status, `rx_data` and `irq` unchanged, and SDA stays released for the rest of the frame until the next START.
- R6: While `ack_en` is 0, even a matching address is not acknowledged and the rest of the frame is ignored as in R5.
- R7: In a write frame each received byte appears on `rx_data`, status becomes 4 and the byte is acknowledged while `ack_en` is 1.
- R8: In a read frame `tx_data` is shifted out MSB first, one bit per SCL clock. When the master acknowledges, status becomes 5 and the value on `tx_data` at the 9th clock is sent as the next byte.
- R9: When the master does not acknowledge a sent byte, status becomes 6 and SDA stays released until the next START.
- R10: STOP (SDA rising while SCL is high) after a frame in which the block was addressed sets status 7 and releases SDA. A STOP with no such frame changes nothing.
- R11: Each status event sets `irq` only while `int_en` is 1. `int_clr` clears `irq`, and an event in the same cycle takes priority over the clear.
- R12: `sda_oe` changes only while the synchronized SCL is low, or on a START or STOP.
- R13: After reset, `sda_oe` is 0, `irq` is 0 and status is 0 (no event).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| own_addr | input | ADDR_W | Programmed 7-bit own address |
| ack_en | input | 1 | Software acknowledge enable |
| int_en | input | 1 | Interrupt enable |
| int_clr | input | 1 | Clears the interrupt flag |
| tx_data | input | DATA_W | Byte to send in a read frame |
| rx_data | output | DATA_W | Last byte received |
| status | output | EV_W | Code of the last event (0 to 7) |
| irq | output | 1 | Interrupt flag |

## Verification
The bench keeps the default address and data widths and overrides SYNC_STAGES to 3. This shows that the detection logic tolerates a longer synchronizer. With each bus phase held for 8 system clocks, the extra latency still leaves the acknowledge drive well inside the SCL low time. That setting brings the R12 timing margin, repeated STARTs part way through a byte, and the broadcast and own addresses under the same bus model. A seeded random mix of addresses, directions and acknowledge-enable settings then runs against a bench function that decides which address bytes should be acknowledged.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;
  localparam int EV_W = 3;

  typedef enum logic [EV_W-1:0] {
    EV_NONE     = 3'd0,
    EV_OWN_WR   = 3'd1,
    EV_OWN_RD   = 3'd2,
    EV_GCALL    = 3'd3,
    EV_RXD      = 3'd4,
    EV_TXD_ACK  = 3'd5,
    EV_TXD_NACK = 3'd6,
    EV_STOP     = 3'd7
  } ev_code_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACK,
    PH_RX,
    PH_TX,
    PH_MACK,
    PH_LOAD
  } phase_e;
endpackage

// File: rtl/i2c_gc_sync.sv
module i2c_gc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  // Reset to the idle bus level (high) so no false condition follows reset.
  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '1;
    else     pipe[0] <= din;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '1;
        else     pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c_gc_cond.sv
module i2c_gc_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_gc_engine.sv
module i2c_gc_engine
  import i2c_gc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              int_en,
  input  logic              int_clr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rx_data,
  output ev_code_e          status,
  output logic              irq,
  output logic              evt,
  output logic              engaged
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  phase_e            phase;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              ph;
  logic              rw;

  // The byte as it stands after the bit sampled on this SCL rise.
  logic [DATA_W-1:0] byte_in;
  logic [ADDR_W-1:0] addr_in;
  logic              rw_in, hit_own, hit_gc;

  assign byte_in = {shreg[DATA_W-2:0], sda_s};
  assign addr_in = byte_in[DATA_W-1 -: ADDR_W];
  assign rw_in   = byte_in[0];
  assign hit_own = (addr_in == own_addr);
  assign hit_gc  = (addr_in == '0) && !rw_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      shreg   <= '0;
      cnt     <= '0;
      ph      <= 1'b0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      rx_data <= '0;
      status  <= EV_NONE;
      evt     <= 1'b0;
      engaged <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (start_det) begin
        phase  <= PH_ADDR;
        cnt    <= '0;
        ph     <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase   <= PH_IDLE;
        cnt     <= '0;
        ph      <= 1'b0;
        sda_oe  <= 1'b0;
        engaged <= 1'b0;
        if (engaged) begin
          status <= EV_STOP;
          evt    <= 1'b1;
        end
      end else begin
        case (phase)
          PH_ADDR: if (scl_rise) begin
            shreg <= byte_in;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) begin
              cnt <= '0;
              if ((hit_own || hit_gc) && ack_en) begin
                phase   <= PH_ACK;
                ph      <= 1'b0;
                engaged <= 1'b1;
                evt     <= 1'b1;
                rw      <= hit_own && rw_in;
                if (hit_own) status <= rw_in ? EV_OWN_RD : EV_OWN_WR;
                else         status <= EV_GCALL;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          PH_ACK: if (scl_fall) begin
            if (!ph) begin
              sda_oe <= 1'b1;
              ph     <= 1'b1;
            end else begin
              ph <= 1'b0;
              if (rw) begin
                phase  <= PH_TX;
                shreg  <= {tx_data[DATA_W-2:0], 1'b0};
                sda_oe <= ~tx_data[DATA_W-1];
              end else begin
                phase  <= PH_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          PH_RX: if (scl_rise) begin
            shreg <= byte_in;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) begin
              cnt     <= '0;
              rx_data <= byte_in;
              status  <= EV_RXD;
              evt     <= 1'b1;
              ph      <= 1'b0;
              phase   <= ack_en ? PH_ACK : PH_IDLE;
            end
          end
          PH_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == LAST) begin
                cnt   <= '0;
                phase <= PH_MACK;
                ph    <= 1'b0;
              end
            end else if (scl_fall) begin
              sda_oe <= ~shreg[DATA_W-1];
              shreg  <= {shreg[DATA_W-2:0], 1'b0};
            end
          end
          PH_MACK: begin
            if (!ph) begin
              if (scl_fall) begin
                sda_oe <= 1'b0;
                ph     <= 1'b1;
              end
            end else if (scl_rise) begin
              ph  <= 1'b0;
              evt <= 1'b1;
              if (sda_s) begin
                status <= EV_TXD_NACK;
                phase  <= PH_IDLE;
              end else begin
                status <= EV_TXD_ACK;
                phase  <= PH_LOAD;
              end
            end
          end
          PH_LOAD: if (scl_fall) begin
            phase  <= PH_TX;
            shreg  <= {tx_data[DATA_W-2:0], 1'b0};
            sda_oe <= ~tx_data[DATA_W-1];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 irq <= 1'b0;
    else if (evt && int_en)  irq <= 1'b1;
    else if (int_clr)        irq <= 1'b0;
  end
endmodule

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave
  import i2c_gc_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              int_en,
  input  logic              int_clr,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  output logic [EV_W-1:0]   status,
  output logic              irq
);
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic       evt, engaged;
  ev_code_e   status_e;

  i2c_gc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({scl_i, sda_i}),
    .dout (line_s)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_gc_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_gc_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .own_addr  (own_addr),
    .ack_en    (ack_en),
    .int_en    (int_en),
    .int_clr   (int_clr),
    .tx_data   (tx_data),
    .sda_oe    (sda_oe),
    .rx_data   (rx_data),
    .status    (status_e),
    .irq       (irq),
    .evt       (evt),
    .engaged   (engaged)
  );

  assign status = status_e;
endmodule

// File: rtl/i2c_gc_slave_chk.sv
module i2c_gc_slave_chk
  import i2c_gc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            scl_s,
  input logic            start_det,
  input logic            stop_det,
  input logic            sda_oe,
  input logic            irq,
  input logic            int_en,
  input logic            int_clr,
  input logic            evt,
  input logic            engaged,
  input logic [EV_W-1:0] status
);
  p_start_release_r1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  p_drive_engaged_r5: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> engaged);

  p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  p_irq_enabled_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(int_en));

  p_irq_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (int_clr && !evt) |=> !irq);

  p_irq_has_code_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (status != EV_NONE));

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> ($past(!scl_s) || $past(start_det || stop_det)));
endmodule

bind i2c_gc_slave i2c_gc_slave_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .irq       (irq),
  .int_en    (int_en),
  .int_clr   (int_clr),
  .evt       (evt),
  .engaged   (engaged),
  .status    (status)
);

// File: tb/tb_i2c_gc_slave.sv
module tb_i2c_gc_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       scl_i, sda_i, sda_oe;
  logic [6:0] own_addr = OWN;
  logic       ack_en = 1'b1, int_en = 1'b1, int_clr = 1'b0;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic [2:0] status;
  logic       irq;

  int checks = 0, fails = 0, viol = 0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_i = m_scl;
  assign sda_i = m_sda & ~sda_oe;

  i2c_gc_slave #(.ADDR_W(7), .DATA_W(8), .SYNC_STAGES(3)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .own_addr(own_addr), .ack_en(ack_en), .int_en(int_en), .int_clr(int_clr),
    .tx_data(tx_data), .rx_data(rx_data), .status(status), .irq(irq)
  );

  // R12 monitor: the open-drain enable must not move while the bus clock is high.
  always @(posedge clk) begin
    if (!rst) begin
      if (sda_oe !== oe_prev && m_scl) viol <= viol + 1;
      oe_prev <= sda_oe;
    end
  end

  function automatic logic addr_acked(input logic [6:0] a, input logic rw,
                                      input logic [6:0] own, input logic ae);
    return ae && ((a == own) || (a == 7'h00 && !rw));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b1; wait_clk(Q);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    m_sda = b; wait_clk(Q);
    m_scl = 1'b1; wait_clk(2*Q);
    s = sda_i;
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(output logic [7:0] b, input logic mack, input logic [7:0] next_tx);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      b = {b[6:0], s};
    end
    m_sda = ~mack; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    tx_data = next_tx; wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q);
    m_sda = 1'b1;
  endtask

  task automatic clear_irq();
    int_clr = 1'b1; wait_clk(1);
    int_clr = 1'b0; wait_clk(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R13 watchdog expired actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ak, s;
    logic [7:0] got, exp_rx;
    int unsigned seed;
    seed = $urandom(32'd4711);

    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    check("R13 reset sda_oe", sda_oe, 0);
    check("R13 reset irq", irq, 0);
    check("R13 reset status", status, 0);

    // Own address write with two data bytes
    bus_start();
    write_byte({OWN, 1'b0}, ak);
    check("R2 own write ack", ak, 1);
    check("R2 status own write", status, 1);
    check("R11 irq set on address", irq, 1);
    clear_irq();
    check("R11 irq cleared", irq, 0);
    write_byte(8'hC3, ak);
    check("R7 data ack", ak, 1);
    check("R7 rx_data", rx_data, 8'hC3);
    check("R7 status data rx", status, 4);
    check("R11 irq on data", irq, 1);
    write_byte(8'h3C, ak);
    check("R7 second rx_data", rx_data, 8'h3C);
    bus_stop();
    wait_clk(2*Q);
    check("R10 status stop", status, 7);
    check("R12 sda released after stop", sda_oe, 0);
    clear_irq();

    // General call
    bus_start();
    write_byte(8'h00, ak);
    check("R4 general call ack", ak, 1);
    check("R4 status general call", status, 3);
    write_byte(8'h81, ak);
    check("R7 general call data", rx_data, 8'h81);
    bus_stop();
    wait_clk(2*Q);
    clear_irq();

    // 0x01 is not a general call
    bus_start();
    write_byte(8'h01, ak);
    check("R4 byte 0x01 not acked", ak, 0);
    check("R4 byte 0x01 status kept", status, 7);
    bus_stop();
    wait_clk(2*Q);

    // Non-matching address
    bus_start();
    write_byte({7'h11, 1'b0}, ak);
    check("R5 mismatch nack", ak, 0);
    check("R5 status unchanged", status, 7);
    check("R5 irq unchanged", irq, 0);
    write_byte(8'h00, ak);
    check("R5 data ignored nack", ak, 0);
    check("R5 rx_data unchanged", rx_data, 8'h81);
    bus_stop();
    wait_clk(2*Q);
    check("R10 stop without frame no event", status, 7);
    check("R10 stop without frame no irq", irq, 0);

    // Acknowledge disabled
    ack_en = 1'b0;
    bus_start();
    write_byte({OWN, 1'b0}, ak);
    check("R6 no ack when disabled", ak, 0);
    check("R6 status unchanged", status, 7);
    write_byte(8'h55, ak);
    check("R6 data ignored", ak, 0);
    check("R6 rx_data unchanged", rx_data, 8'h81);
    bus_stop();
    wait_clk(2*Q);
    ack_en = 1'b1;

    // Read frame: ack first byte, nack second, then clock a released byte
    tx_data = 8'hA5;
    bus_start();
    write_byte({OWN, 1'b1}, ak);
    check("R3 own read ack", ak, 1);
    check("R3 status own read", status, 2);
    read_byte(got, 1'b1, 8'h3E);
    check("R8 first byte MSB first", got, 8'hA5);
    check("R8 status sent acked", status, 5);
    read_byte(got, 1'b0, 8'hFF);
    check("R8 next byte loaded", got, 8'h3E);
    check("R9 status sent nacked", status, 6);
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      got = {got[6:0], s};
    end
    check("R9 sda released after nack", got, 8'hFF);
    check("R9 status kept after nack", status, 6);
    bus_stop();
    wait_clk(2*Q);
    check("R10 stop after read", status, 7);

    // Interrupt disabled
    clear_irq();
    int_en = 1'b0;
    bus_start();
    write_byte({OWN, 1'b0}, ak);
    check("R11 irq stays low when disabled", irq, 0);
    check("R2 status with irq disabled", status, 1);
    bus_stop();
    wait_clk(2*Q);
    int_en = 1'b1;

    // Repeated START part way through a data byte
    tx_data = 8'h96;
    bus_start();
    write_byte({OWN, 1'b0}, ak);
    clock_bit(1'b1, s);
    clock_bit(1'b0, s);
    clock_bit(1'b1, s);
    bus_start();
    write_byte({OWN, 1'b1}, ak);
    check("R1 repeated start address ack", ak, 1);
    check("R1 repeated start status", status, 2);
    read_byte(got, 1'b0, 8'h00);
    check("R1 read after repeated start", got, 8'h96);
    bus_stop();
    wait_clk(2*Q);
    clear_irq();

    // Seeded random mix
    exp_rx = rx_data;
    for (int it = 0; it < 24; it++) begin
      logic [6:0] a;
      logic       rw, ae, exp_ak;
      logic [7:0] d, tx;
      int         nb;
      ae = ($urandom % 4) != 0;
      ack_en = ae;
      if ($urandom % 3 == 0)      a = OWN;
      else if ($urandom % 3 == 0) a = 7'h00;
      else                        a = 7'($urandom);
      rw = 1'($urandom % 2);
      tx = 8'($urandom);
      tx_data = tx;
      exp_ak = addr_acked(a, rw, OWN, ae);
      bus_start();
      write_byte({a, rw}, ak);
      check("R2/R4/R5/R6 random address ack", ak, exp_ak);
      if (rw) begin
        read_byte(got, 1'b0, 8'h00);
        check("R8/R5 random read byte", got, exp_ak ? tx : 8'hFF);
      end else begin
        nb = 1 + int'($urandom % 2);
        for (int k = 0; k < nb; k++) begin
          d = 8'($urandom);
          write_byte(d, ak);
          if (exp_ak) exp_rx = d;
          check("R7/R5 random data ack", ak, exp_ak);
          check("R7/R5 random rx_data", rx_data, exp_rx);
        end
      end
      bus_stop();
      wait_clk(2*Q);
    end
    ack_en = 1'b1;

    check("R12 sda_oe changes only with SCL low", viol, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule